// File: doc/BRIEF.md
# Power-On Reset and Stop-Mode Clock Controller

This block owns the internal reset of a small processor core and the deepest power-saving state. When supply is first applied, it keeps the core in reset for a fixed count of oscillator clocks. No external RC network is needed. It also records that a power-up happened, in a flag that software can read and clear.

Software enters two low-power states through single-cycle request pulses. The light state gates only the CPU clock. The deep state gates every internal clock. The deep state is left only by a reset on the pin or by a qualifying edge on an enabled external interrupt line. After such a wake, the same hold counter times a crystal warm-up before clocks come back.

The block has no data stream, so every pin is a plain control or status signal. The raw oscillator clock always runs into the block. The outputs are enables that the clock tree uses for gating.

Top module: `pwr_reset_ctrl`

## Requirements
- R1: After `pwr_rst_n` is released, `core_rst` and `strobe_force` stay high for exactly HOLD_CYCLES rising clock edges and fall on the HOLD_CYCLES-th edge. While reset is held, both clock enables are 1.
- R2: A low level on `pwr_rst_n` sets `por_flag` at once. Only a `flag_clr` pulse clears it, at the next edge. A reset through `rst_pin` leaves the flag unchanged.
- R3: A `stop_req` pulse while running drives `cpu_clk_en` and `periph_clk_en` to 0 and `stop_bit` to 1 at the next edge.
- R4: In the deep state, nothing ends the state except a reset or an enabled wake edge. `irq_pending` has no effect. An edge of the wrong polarity has no effect. An edge on a line whose `xint_en` bit is 0 has no effect.
- R5: Each wake line has its own polarity. Bit i of XINT_RISE set to 1 means line i wakes on a rising edge; 0 means it wakes on a falling edge. A wake edge passes through a two-flop synchronizer and one edge register. Both clock enables return exactly HOLD_CYCLES+3 edges after the line changes. `stop_bit` stays 1 until that edge and clears on it.
- R6: An `idle_req` pulse while running sets `idle_bit` and drops `cpu_clk_en` while `periph_clk_en` stays 1, at the next edge. `irq_pending` (or an enabled wake edge) returns the block to running at the following edge.
- R7: `rst_pin` is active high and passes through a two-flop synchronizer. `core_rst` rises on the 3rd edge after the pin rises. After a warm run, `core_rst` falls on the 3rd edge after the pin falls.
- R8: A pin reset taken during the deep state or during warm-up clears `stop_bit`. On release it restarts the full hold, and `core_rst` falls HOLD_CYCLES+3 edges after the pin falls.
- R9: If `stop_req` and `idle_req` arrive in the same cycle, the deep state wins and `idle_bit` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock, never gated |
| pwr_rst_n | input | 1 | Asynchronous power-up indication, low while supply is not valid |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| stop_req | input | 1 | Software pulse requesting the deep stop state |
| idle_req | input | 1 | Software pulse requesting the light idle state |
| flag_clr | input | 1 | Software pulse clearing the power-up flag |
| irq_pending | input | 1 | Any enabled interrupt is pending (ends idle only) |
| xint_line | input | NUM_XINT | Raw external interrupt lines used for wake |
| xint_en | input | NUM_XINT | Per-line wake enable |
| core_rst | output | 1 | Reset to the core, active high |
| strobe_force | output | 1 | Holds the bus address and fetch strobes high during reset |
| cpu_clk_en | output | 1 | Clock enable for the CPU |
| periph_clk_en | output | 1 | Clock enable for the peripherals |
| stop_bit | output | 1 | Software-visible stop state, self-clearing |
| idle_bit | output | 1 | Software-visible idle state |
| por_flag | output | 1 | Power-up flag |

## Verification
The assertions assume that `stop_req`, `idle_req` and `flag_clr` are single-cycle pulses changing away from the clock edge. They also assume that `rst_pin` and every wake line hold each level for at least three cycles, so the synchronizers see every change. The stimulus drives all inputs at the falling clock edge and never issues a software pulse while the core would be unable to execute. Each interrupt or pin level is held for many cycles before it changes again. Power-up release is driven away from the edge, so the asynchronous flag set and the hold load have a clean start.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_RST_HOLD = 3'd0,
    ST_RST_PIN  = 3'd1,
    ST_RUN      = 3'd2,
    ST_IDLE     = 3'd3,
    ST_STOP     = 3'd4,
    ST_WAKE     = 3'd5
  } pwr_state_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pwr_level_sync.sv
module pwr_level_sync
  import pwr_ctrl_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] stages;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stages <= '0;
    else         stages <= {stages[SYNC_STAGES-2:0], din};
  end

  assign dout = stages[SYNC_STAGES-1];
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int unsigned        NUM_XINT  = 4,
  parameter logic [NUM_XINT-1:0] XINT_RISE = '0
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic [NUM_XINT-1:0] lines,
  input  logic [NUM_XINT-1:0] enables,
  output logic                wake_hit
);
  logic [NUM_XINT-1:0] synced;
  logic [NUM_XINT-1:0] last;
  logic [NUM_XINT-1:0] hit;

  for (genvar i = 0; i < NUM_XINT; i++) begin : g_line
    pwr_level_sync u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .din    (lines[i]),
      .dout   (synced[i])
    );

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) last[i] <= 1'b0;
      else         last[i] <= synced[i];
    end

    if (XINT_RISE[i]) begin : g_rise
      assign hit[i] = synced[i] & ~last[i];
    end else begin : g_fall
      assign hit[i] = ~synced[i] & last[i];
    end
  end

  assign wake_hit = |(hit & enables);
endmodule

// File: rtl/pwr_hold_counter.sv
module pwr_hold_counter #(
  parameter int unsigned HOLD_CYCLES = 65536
) (
  input  logic clk,
  input  logic arst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int unsigned CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] START = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                 cnt <= START;
    else if (load)               cnt <= START;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       pin_active,
  input  logic       wake_hit,
  input  logic       stop_req,
  input  logic       idle_req,
  input  logic       irq_pending,
  input  logic       hold_done,
  output pwr_state_e state,
  output logic       hold_load,
  output logic       hold_run
);
  pwr_state_e nxt;
  logic       osc_cold;

  always_comb begin
    nxt = state;
    if (pin_active) begin
      nxt = ST_RST_PIN;
    end else begin
      unique case (state)
        ST_RST_HOLD: if (hold_done) nxt = ST_RUN;
        ST_RST_PIN:  nxt = osc_cold ? ST_RST_HOLD : ST_RUN;
        ST_RUN: begin
          if (stop_req)      nxt = ST_STOP;
          else if (idle_req) nxt = ST_IDLE;
        end
        ST_IDLE:     if (irq_pending || wake_hit) nxt = ST_RUN;
        ST_STOP:     if (wake_hit) nxt = ST_WAKE;
        ST_WAKE:     if (hold_done) nxt = ST_RUN;
        default:     nxt = ST_RST_HOLD;
      endcase
    end
  end

  assign hold_load = (nxt != state) && (nxt == ST_RST_HOLD || nxt == ST_WAKE);
  assign hold_run  = (state == ST_RST_HOLD) || (state == ST_WAKE);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state    <= ST_RST_HOLD;
      osc_cold <= 1'b1;
    end else begin
      state <= nxt;
      if (nxt == ST_STOP)     osc_cold <= 1'b1;
      else if (nxt == ST_RUN) osc_cold <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_reset_ctrl.sv
module pwr_reset_ctrl
  import pwr_ctrl_pkg::*;
#(
  parameter int unsigned         HOLD_CYCLES = 65536,
  parameter int unsigned         NUM_XINT    = 4,
  parameter logic [NUM_XINT-1:0] XINT_RISE   = NUM_XINT'(4'b0101)
) (
  input  logic                clk_osc,
  input  logic                pwr_rst_n,
  input  logic                rst_pin,
  input  logic                stop_req,
  input  logic                idle_req,
  input  logic                flag_clr,
  input  logic                irq_pending,
  input  logic [NUM_XINT-1:0] xint_line,
  input  logic [NUM_XINT-1:0] xint_en,
  output logic                core_rst,
  output logic                strobe_force,
  output logic                cpu_clk_en,
  output logic                periph_clk_en,
  output logic                stop_bit,
  output logic                idle_bit,
  output logic                por_flag
);
  pwr_state_e mode_state;
  logic       pin_sync;
  logic       wake_hit;
  logic       hold_load;
  logic       hold_run;
  logic       hold_done;
  logic       in_reset;

  pwr_level_sync u_pin_sync (
    .clk    (clk_osc),
    .arst_n (pwr_rst_n),
    .din    (rst_pin),
    .dout   (pin_sync)
  );

  pwr_wake_detect #(
    .NUM_XINT  (NUM_XINT),
    .XINT_RISE (XINT_RISE)
  ) u_wake (
    .clk      (clk_osc),
    .arst_n   (pwr_rst_n),
    .lines    (xint_line),
    .enables  (xint_en),
    .wake_hit (wake_hit)
  );

  pwr_hold_counter #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_hold (
    .clk    (clk_osc),
    .arst_n (pwr_rst_n),
    .load   (hold_load),
    .run    (hold_run),
    .done   (hold_done)
  );

  pwr_mode_fsm u_fsm (
    .clk         (clk_osc),
    .arst_n      (pwr_rst_n),
    .pin_active  (pin_sync),
    .wake_hit    (wake_hit),
    .stop_req    (stop_req),
    .idle_req    (idle_req),
    .irq_pending (irq_pending),
    .hold_done   (hold_done),
    .state       (mode_state),
    .hold_load   (hold_load),
    .hold_run    (hold_run)
  );

  always_ff @(posedge clk_osc or negedge pwr_rst_n) begin
    if (!pwr_rst_n)    por_flag <= 1'b1;
    else if (flag_clr) por_flag <= 1'b0;
  end

  assign in_reset      = (mode_state == ST_RST_HOLD) || (mode_state == ST_RST_PIN);
  assign core_rst      = in_reset;
  assign strobe_force  = in_reset;
  assign cpu_clk_en    = in_reset || (mode_state == ST_RUN);
  assign periph_clk_en = in_reset || (mode_state == ST_RUN) || (mode_state == ST_IDLE);
  assign stop_bit      = (mode_state == ST_STOP) || (mode_state == ST_WAKE);
  assign idle_bit      = (mode_state == ST_IDLE);
endmodule

// File: rtl/pwr_reset_ctrl_chk.sv
module pwr_reset_ctrl_chk
  import pwr_ctrl_pkg::*;
(
  input logic       clk,
  input logic       pwr_rst_n,
  input logic       rst_sync,
  input logic       wake_hit,
  input pwr_state_e state,
  input logic       stop_req,
  input logic       flag_clr,
  input logic       core_rst,
  input logic       cpu_clk_en,
  input logic       periph_clk_en,
  input logic       stop_bit,
  input logic       por_flag
);
  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (por_flag && !flag_clr) |=> por_flag);

  // R2
  flag_noset_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !por_flag |=> !por_flag);

  // R3
  stop_entry_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (cpu_clk_en && !core_rst && stop_req && !rst_sync)
      |=> (!cpu_clk_en && !periph_clk_en && stop_bit));

  // R4
  stop_stays_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (state == ST_STOP && !rst_sync && !wake_hit) |=> (state == ST_STOP));

  // R5
  wake_clock_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    ($fell(stop_bit) && !core_rst) |-> (cpu_clk_en && periph_clk_en));

  // R6
  idle_gate_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (state == ST_IDLE) |-> (periph_clk_en && !cpu_clk_en));

  // R7
  pin_reset_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rst_sync |=> core_rst);

  // R8
  reset_clears_stop_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    core_rst |-> !stop_bit);
endmodule

bind pwr_reset_ctrl pwr_reset_ctrl_chk u_chk (
  .clk           (clk_osc),
  .pwr_rst_n     (pwr_rst_n),
  .rst_sync      (pin_sync),
  .wake_hit      (wake_hit),
  .state         (mode_state),
  .stop_req      (stop_req),
  .flag_clr      (flag_clr),
  .core_rst      (core_rst),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .stop_bit      (stop_bit),
  .por_flag      (por_flag)
);

// File: tb/test_pwr_reset_ctrl.sv
`timescale 1ns/1ps
module test_pwr_reset_ctrl;
  localparam int HOLD = 20;
  localparam int NX   = 4;

  logic          clk_osc = 1'b0;
  logic          pwr_rst_n = 1'b0;
  logic          rst_pin = 1'b0;
  logic          stop_req = 1'b0;
  logic          idle_req = 1'b0;
  logic          flag_clr = 1'b0;
  logic          irq_pending = 1'b0;
  logic [NX-1:0] xint_line = '0;
  logic [NX-1:0] xint_en = '0;
  logic core_rst, strobe_force, cpu_clk_en, periph_clk_en, stop_bit, idle_bit, por_flag;

  always #2.5 clk_osc = ~clk_osc;

  pwr_reset_ctrl #(
    .HOLD_CYCLES (HOLD),
    .NUM_XINT    (NX),
    .XINT_RISE   (4'b0101)
  ) i_pwr_reset_ctrl (
    .clk_osc, .pwr_rst_n, .rst_pin, .stop_req, .idle_req, .flag_clr,
    .irq_pending, .xint_line, .xint_en, .core_rst, .strobe_force,
    .cpu_clk_en, .periph_clk_en, .stop_bit, .idle_bit, .por_flag
  );

  typedef struct {
    string tag;
    string what;
    int    exp;
  } exp_item_t;

  exp_item_t sb_q[$];
  int n_tests = 0;
  int n_fail  = 0;

  task automatic push_exp(input string tag, input string what, input int exp);
    exp_item_t it;
    it.tag = tag; it.what = what; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic observe(input int act);
    exp_item_t it;
    it = sb_q.pop_front();
    n_tests++;
    if (act != it.exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", it.tag, it.what, act, it.exp);
    end
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    push_exp(tag, what, exp);
    observe(act);
  endtask

  // mode 0: wait for core_rst==0, 1: core_rst==1, 2: cpu_clk_en==1
  // stop_early counts samples where stop_bit was already 0 before the end
  task automatic count_edges(input int mode, output int n, output int stop_early);
    n = 0;
    stop_early = 0;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk_osc);
      n++;
      @(negedge clk_osc);
      if ((mode == 0 && !core_rst) || (mode == 1 && core_rst) ||
          (mode == 2 && cpu_clk_en)) break;
      if (!stop_bit) stop_early++;
    end
  endtask

  task automatic pulse_stop();
    stop_req = 1'b1;
    @(negedge clk_osc);
    stop_req = 1'b0;
  endtask

  task automatic run_main();
    int n, se;
    @(negedge clk_osc);
    check("R1", "core_rst in power reset", int'(core_rst), 1);
    check("R1", "strobe_force in power reset", int'(strobe_force), 1);
    check("R1", "cpu_clk_en in power reset", int'(cpu_clk_en), 1);
    check("R2", "por_flag after power-up", int'(por_flag), 1);
    pwr_rst_n = 1'b1;
    count_edges(0, n, se);
    check("R1", "hold length in edges", n, HOLD);
    check("R1", "strobe_force after hold", int'(strobe_force), 0);
    check("R2", "por_flag survives hold", int'(por_flag), 1);

    flag_clr = 1'b1;
    @(negedge clk_osc);
    flag_clr = 1'b0;
    check("R2", "por_flag after clear", int'(por_flag), 0);

    // warm pin reset
    rst_pin = 1'b1;
    count_edges(1, n, se);
    check("R7", "pin assert latency", n, 3);
    repeat (4) @(negedge clk_osc);
    rst_pin = 1'b0;
    count_edges(0, n, se);
    check("R7", "warm release latency", n, 3);
    check("R2", "pin reset leaves flag", int'(por_flag), 0);

    // idle
    idle_req = 1'b1;
    @(negedge clk_osc);
    idle_req = 1'b0;
    check("R6", "cpu_clk_en in idle", int'(cpu_clk_en), 0);
    check("R6", "periph_clk_en in idle", int'(periph_clk_en), 1);
    check("R6", "idle_bit in idle", int'(idle_bit), 1);
    repeat (3) @(negedge clk_osc);
    irq_pending = 1'b1;
    @(negedge clk_osc);
    irq_pending = 1'b0;
    check("R6", "cpu_clk_en after interrupt", int'(cpu_clk_en), 1);
    check("R6", "idle_bit after interrupt", int'(idle_bit), 0);

    // simultaneous stop and idle
    stop_req = 1'b1;
    idle_req = 1'b1;
    @(negedge clk_osc);
    stop_req = 1'b0;
    idle_req = 1'b0;
    check("R9", "stop_bit wins", int'(stop_bit), 1);
    check("R9", "idle_bit stays low", int'(idle_bit), 0);
    check("R3", "cpu_clk_en in stop", int'(cpu_clk_en), 0);
    check("R3", "periph_clk_en in stop", int'(periph_clk_en), 0);

    // ignored stimuli in stop
    xint_en = 4'b0011;
    irq_pending = 1'b1;
    xint_line[1] = 1'b1;  // rising on falling-type line: wrong polarity
    xint_line[2] = 1'b1;  // rising-type but disabled
    xint_line[3] = 1'b1;
    repeat (5) @(negedge clk_osc);
    xint_line[3] = 1'b0;  // falling-type but disabled
    repeat (8) @(negedge clk_osc);
    irq_pending = 1'b0;
    check("R4", "stop_bit after ignored events", int'(stop_bit), 1);
    check("R4", "periph_clk_en after ignored events", int'(periph_clk_en), 0);

    // falling-edge wake on line 1
    xint_line[1] = 1'b0;
    count_edges(2, n, se);
    check("R5", "falling wake latency", n, HOLD + 3);
    check("R5", "stop_bit cleared late only", se, 0);
    check("R5", "stop_bit after wake", int'(stop_bit), 0);

    // rising-edge wake on line 0
    pulse_stop();
    repeat (3) @(negedge clk_osc);
    xint_line[0] = 1'b1;
    count_edges(2, n, se);
    check("R5", "rising wake latency", n, HOLD + 3);
    check("R5", "periph_clk_en after rising wake", int'(periph_clk_en), 1);

    // pin reset during stop: cold restart
    pulse_stop();
    repeat (3) @(negedge clk_osc);
    rst_pin = 1'b1;
    count_edges(1, n, se);
    check("R8", "pin assert latency in stop", n, 3);
    check("R8", "stop_bit cleared by reset", int'(stop_bit), 0);
    repeat (4) @(negedge clk_osc);
    rst_pin = 1'b0;
    count_edges(0, n, se);
    check("R8", "cold release latency", n, HOLD + 3);
    check("R2", "flag after cold pin reset", int'(por_flag), 0);

    // new power-up event sets the flag at once
    pwr_rst_n = 1'b0;
    #1;
    check("R2", "por_flag on power loss", int'(por_flag), 1);
    check("R1", "core_rst on power loss", int'(core_rst), 1);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (20000) @(posedge clk_osc);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule